// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a byte-wide host bus and the program/erase sequencer of a flash controller. It interprets bytes written on a synchronous write strobe as commands. Some commands take effect in one write. Program and erase take two writes, a setup byte followed by an operand or a confirm byte. When a sequence completes, the block issues a single-cycle request, with its address and data, to the sequencer.

The block also decides what a read returns. A read can return array data supplied by the storage, the status byte, or the identification codes. It switches to status reporting on its own once a program or erase sequence has been entered.

The sequencer reports completion, failure, low programming voltage and suspend acknowledge. The decoder folds these reports into sticky status bits. A synchronous deep power-down input returns the whole decoder to its power-up condition.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and while `pd_i` is high, the decoder is in array read mode with no operation pending. All four request outputs are low and the status byte is 80h. While `pd_i` is high, `rd_data_o` is 00h. Once `pd_i` falls, reads return array data.
- R2: Writing FFh selects array read mode. A read then returns `array_data_i` one cycle after `rd_en_i` is sampled high.
- R3: Writing 40h or 10h arms programming. The next write raises `prog_req_o` for exactly one cycle, in the cycle after that write. It carries that write's address on `seq_addr_o` and its data byte on `seq_data_o`, and reads switch to status.
- R4: Writing 20h arms erase. A following write of D0h raises `erase_req_o` for one cycle, with the confirm write's address on `seq_addr_o`.
- R5: If any byte other than D0h follows 20h, no erase request is issued. Both the erase error bit (bit 5) and the program error bit (bit 4) are set.
- R6: Writing 70h selects status mode. In this mode, the status byte is captured in the cycle in which `rd_en_i` rises. The captured value is held unchanged until `rd_en_i` falls and rises again.
- R7: Writing 50h while idle clears status bits 5, 4 and 3.
- R8: While a program or erase is in flight and not suspended, every command byte except 70h is ignored. The one exception is B0h during an erase.
- R9: While an erase is in flight, B0h raises `susp_req_o` for one cycle. Once `seq_susp_ack_i` is high, D0h raises `resume_req_o` for one cycle and FFh selects array reads. In that suspended state, the status byte shows bits 7 and 6 set.
- R10: Writing 90h selects identification mode. A read at address 0 returns 31h. A read at address 1 returns 7Ch when `TOP_BOOT` is 1, or 7Dh when it is 0. Any other address returns 00h.
- R11: A first-cycle byte that is not a defined command is ignored, and the current read mode is kept.
- R12: Status bit 7 is low while an operation is in flight and not suspended. It is high otherwise. When `seq_done_i` arrives with `seq_err_i` set, bit 4 is set after a program and bit 5 after an erase. When `seq_done_i` arrives with `seq_vlow_i` set, bit 3 is set as well as the matching error bit. Bits 2..0 read 0.
- R13: While status bit 3 is set, a completed program or erase sequence issues no request and sets the matching error bit instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Deep power-down, synchronous clear while high |
| wr_en_i | input | 1 | Write strobe, one command byte per cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data / command byte |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Array byte for the current read address |
| rd_data_o | output | 8 | Registered read data |
| prog_req_o | output | 1 | Byte program request pulse |
| erase_req_o | output | 1 | Region erase request pulse |
| susp_req_o | output | 1 | Erase suspend request pulse |
| resume_req_o | output | 1 | Erase resume request pulse |
| seq_addr_o | output | ADDR_W | Target address for the sequencer |
| seq_data_o | output | 8 | Byte to program |
| seq_done_i | input | 1 | Sequencer finished the current operation |
| seq_err_i | input | 1 | Operation failed (with done) |
| seq_vlow_i | input | 1 | Programming voltage was low (with done) |
| seq_susp_ack_i | input | 1 | Erase is suspended |

## Verification
On every cycle, the embedded assertions check the following. At most one request pulse is high at a time. Requests follow a write, and an erase request follows a confirm byte. Power-down keeps requests low and read data at zero. A status read stays frozen while the strobe is held. A clear empties the error bits, and a bad erase sequence sets both of them. Ordering effects need the bench's scenarios, whose reference model is compared on every clock. These effects are: which bytes are ignored while busy or suspended, the switch of read source after a sequence, the identification codes, and error reporting through a later read.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT     = 8'h10;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;
    localparam logic [7:0] CMD_IDENT        = 8'h90;

    localparam logic [7:0] ID_MAKER      = 8'h31;
    localparam logic [7:0] ID_DEV_TOP    = 8'h7C;
    localparam logic [7:0] ID_DEV_BOTTOM = 8'h7D;

    // status byte bit positions (decoded by host software)
    localparam int SB_READY = 7;
    localparam int SB_SUSP  = 6;
    localparam int SB_ERASE = 5;
    localparam int SB_PROG  = 4;
    localparam int SB_VLOW  = 3;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2
    } rd_src_e;

    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_PROG  = 2'd1,
        ARM_ERASE = 2'd2
    } arm_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

endpackage

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              done_i,
    input  logic              susp_ack_i,
    input  logic              vlow_flag_i,
    output rd_src_e           mode_o,
    output logic              busy_o,
    output op_e               op_o,
    output logic              prog_req_o,
    output logic              erase_req_o,
    output logic              susp_req_o,
    output logic              resume_req_o,
    output logic [ADDR_W-1:0] seq_addr_o,
    output logic [7:0]        seq_data_o,
    output logic              clr_o,
    output logic              set_ps_o,
    output logic              set_es_o
);

    typedef struct packed {
        rd_src_e           mode;
        arm_e              arm;
        logic              busy;
        op_e               op;
        logic              prog_req;
        logic              erase_req;
        logic              susp_req;
        logic              resume_req;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        mode: RD_ARRAY, arm: ARM_NONE, busy: 1'b0, op: OP_PROG,
        prog_req: 1'b0, erase_req: 1'b0, susp_req: 1'b0, resume_req: 1'b0,
        addr: '0, data: '0
    };

    fsm_t q, d;
    logic is_idle_cmd;

    // decode of first-cycle commands when nothing is in flight
    always_comb begin
        is_idle_cmd = (q.arm == ARM_NONE) && !q.busy;
    end

    always_comb begin
        d            = q;
        d.prog_req   = 1'b0;
        d.erase_req  = 1'b0;
        d.susp_req   = 1'b0;
        d.resume_req = 1'b0;
        clr_o        = 1'b0;
        set_ps_o     = 1'b0;
        set_es_o     = 1'b0;
        if (pd_i) begin
            d = FSM_RST;
        end else begin
            if (done_i) begin
                d.busy = 1'b0;
            end
            if (wr_en_i) begin
                case (q.arm)
                    ARM_PROG: begin
                        d.arm  = ARM_NONE;
                        d.mode = RD_STATUS;
                        if (vlow_flag_i) begin
                            set_ps_o = 1'b1;
                        end else begin
                            d.prog_req = 1'b1;
                            d.busy     = 1'b1;
                            d.op       = OP_PROG;
                            d.addr     = wr_addr_i;
                            d.data     = wr_data_i;
                        end
                    end
                    ARM_ERASE: begin
                        d.arm  = ARM_NONE;
                        d.mode = RD_STATUS;
                        if (wr_data_i != CMD_CONFIRM) begin
                            set_ps_o = 1'b1;
                            set_es_o = 1'b1;
                        end else if (vlow_flag_i) begin
                            set_es_o = 1'b1;
                        end else begin
                            d.erase_req = 1'b1;
                            d.busy      = 1'b1;
                            d.op        = OP_ERASE;
                            d.addr      = wr_addr_i;
                        end
                    end
                    default: begin
                        if (q.busy && !susp_ack_i) begin
                            if (wr_data_i == CMD_READ_STATUS) begin
                                d.mode = RD_STATUS;
                            end else if (wr_data_i == CMD_SUSPEND && q.op == OP_ERASE) begin
                                d.susp_req = 1'b1;
                            end
                        end else if (q.busy) begin
                            case (wr_data_i)
                                CMD_READ_STATUS: d.mode = RD_STATUS;
                                CMD_READ_ARRAY:  d.mode = RD_ARRAY;
                                CMD_CONFIRM: begin
                                    d.resume_req = 1'b1;
                                    d.mode       = RD_STATUS;
                                end
                                default: ;
                            endcase
                        end else if (is_idle_cmd) begin
                            case (wr_data_i)
                                CMD_READ_ARRAY:   d.mode = RD_ARRAY;
                                CMD_READ_STATUS:  d.mode = RD_STATUS;
                                CMD_CLEAR_STATUS: clr_o  = 1'b1;
                                CMD_IDENT:        d.mode = RD_IDENT;
                                CMD_PROG_SETUP, CMD_PROG_ALT: begin
                                    d.arm  = ARM_PROG;
                                    d.mode = RD_STATUS;
                                end
                                CMD_ERASE_SETUP: begin
                                    d.arm  = ARM_ERASE;
                                    d.mode = RD_STATUS;
                                end
                                default: ;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= FSM_RST;
        end else begin
            q <= d;
        end
    end

    assign mode_o       = q.mode;
    assign busy_o       = q.busy;
    assign op_o         = q.op;
    assign prog_req_o   = q.prog_req;
    assign erase_req_o  = q.erase_req;
    assign susp_req_o   = q.susp_req;
    assign resume_req_o = q.resume_req;
    assign seq_addr_o   = q.addr;
    assign seq_data_o   = q.data;

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req_o, erase_req_o, susp_req_o, resume_req_o})); // R3
    AST_PROG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> $past(wr_en_i)); // R3
    AST_ERASE_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |-> ($past(wr_data_i) == CMD_CONFIRM && $past(wr_en_i))); // R4
    AST_POWERDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> !(prog_req_o || erase_req_o || susp_req_o || resume_req_o)); // R1
    AST_RESUME_ONLY_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req_o |-> $past(susp_ack_i)); // R9

endmodule

// File: rtl/fcd_status_reg.sv
module fcd_status_reg
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_i,
    input  logic       clr_i,
    input  logic       set_ps_i,
    input  logic       set_es_i,
    input  logic       done_i,
    input  logic       err_i,
    input  logic       vlow_i,
    input  op_e        op_i,
    input  logic       busy_i,
    input  logic       susp_ack_i,
    output logic [7:0] status_o,
    output logic       vlow_flag_o
);

    typedef struct packed {
        logic es;
        logic ps;
        logic vl;
    } sticky_t;

    sticky_t q, d;
    logic    fail_any;

    always_comb begin
        fail_any = done_i && (err_i || vlow_i);
        d        = q;
        if (pd_i) begin
            d = '0;
        end else begin
            if (clr_i) begin
                d = '0;
            end
            if (set_ps_i) d.ps = 1'b1;
            if (set_es_i) d.es = 1'b1;
            if (fail_any) begin
                if (op_i == OP_ERASE) d.es = 1'b1;
                else                  d.ps = 1'b1;
            end
            if (done_i && vlow_i) d.vl = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status_o           = '0;
        status_o[SB_READY] = !busy_i || susp_ack_i;
        status_o[SB_SUSP]  = busy_i && susp_ack_i;
        status_o[SB_ERASE] = q.es;
        status_o[SB_PROG]  = q.ps;
        status_o[SB_VLOW]  = q.vl;
    end

    assign vlow_flag_o = q.vl;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !done_i && !set_ps_i && !set_es_i) |=> (status_o[5:3] == 3'b000)); // R7
    AST_BAD_SEQ_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ps_i && set_es_i && !pd_i) |=> (status_o[SB_ERASE] && status_o[SB_PROG])); // R5
    AST_VLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[SB_VLOW] && !clr_i && !pd_i) |=> status_o[SB_VLOW]); // R13

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  rd_src_e           mode_i,
    input  logic [7:0]        status_i,
    input  logic [7:0]        array_data_i,
    output logic [7:0]        rd_data_o
);

    localparam logic [7:0] DEV_CODE = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOTTOM;

    typedef struct packed {
        logic       rd_seen;
        logic [7:0] data;
    } rd_t;

    rd_t        q, d;
    logic [7:0] ident_byte;

    always_comb begin
        if (rd_addr_i == ADDR_W'(0))      ident_byte = ID_MAKER;
        else if (rd_addr_i == ADDR_W'(1)) ident_byte = DEV_CODE;
        else                              ident_byte = 8'h00;
    end

    always_comb begin
        d = q;
        if (pd_i) begin
            d = '0;
        end else begin
            d.rd_seen = rd_en_i;
            if (rd_en_i) begin
                case (mode_i)
                    RD_ARRAY:  d.data = array_data_i;
                    RD_IDENT:  d.data = ident_byte;
                    RD_STATUS: if (!q.rd_seen) d.data = status_i;
                    default:   d.data = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data_o = q.data;

    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RD_STATUS && rd_en_i && q.rd_seen && !pd_i) |=> $stable(rd_data_o)); // R6
    AST_POWERDOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> (rd_data_o == 8'h00)); // R1

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [7:0]        array_data_i,
    output logic [7:0]        rd_data_o,
    output logic              prog_req_o,
    output logic              erase_req_o,
    output logic              susp_req_o,
    output logic              resume_req_o,
    output logic [ADDR_W-1:0] seq_addr_o,
    output logic [7:0]        seq_data_o,
    input  logic              seq_done_i,
    input  logic              seq_err_i,
    input  logic              seq_vlow_i,
    input  logic              seq_susp_ack_i
);

    rd_src_e    mode;
    op_e        op;
    logic       busy;
    logic       clr, set_ps, set_es, vlow_flag;
    logic [7:0] status;

    fcd_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_i         (pd_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .done_i       (seq_done_i),
        .susp_ack_i   (seq_susp_ack_i),
        .vlow_flag_i  (vlow_flag),
        .mode_o       (mode),
        .busy_o       (busy),
        .op_o         (op),
        .prog_req_o   (prog_req_o),
        .erase_req_o  (erase_req_o),
        .susp_req_o   (susp_req_o),
        .resume_req_o (resume_req_o),
        .seq_addr_o   (seq_addr_o),
        .seq_data_o   (seq_data_o),
        .clr_o        (clr),
        .set_ps_o     (set_ps),
        .set_es_o     (set_es)
    );

    fcd_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_i        (pd_i),
        .clr_i       (clr),
        .set_ps_i    (set_ps),
        .set_es_i    (set_es),
        .done_i      (seq_done_i),
        .err_i       (seq_err_i),
        .vlow_i      (seq_vlow_i),
        .op_i        (op),
        .busy_i      (busy),
        .susp_ack_i  (seq_susp_ack_i),
        .status_o    (status),
        .vlow_flag_o (vlow_flag)
    );

    fcd_read_mux #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_rdmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_i         (pd_i),
        .rd_en_i      (rd_en_i),
        .rd_addr_i    (rd_addr_i),
        .mode_i       (mode),
        .status_i     (status),
        .array_data_i (array_data_i),
        .rd_data_o    (rd_data_o)
    );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    array_data;
    logic [7:0]    rd_data;
    logic          prog_req, erase_req, susp_req, resume_req;
    logic [AW-1:0] seq_addr;
    logic [7:0]    seq_data;
    logic          done = 1'b0, err = 1'b0, vlow = 1'b0, ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    assign array_data = rd_addr[7:0] ^ 8'h5A;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .TOP_BOOT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .pd_i(pd),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .array_data_i(array_data),
        .rd_data_o(rd_data),
        .prog_req_o(prog_req), .erase_req_o(erase_req),
        .susp_req_o(susp_req), .resume_req_o(resume_req),
        .seq_addr_o(seq_addr), .seq_data_o(seq_data),
        .seq_done_i(done), .seq_err_i(err), .seq_vlow_i(vlow),
        .seq_susp_ack_i(ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_mode;   // 0 array, 1 status, 2 ident
    int         m_arm;    // 0 none, 1 program, 2 erase
    bit         m_busy, m_erase_op, m_es, m_ps, m_vl, m_seen;
    logic [7:0] m_rd;
    bit         e_prog, e_erase, e_susp, e_res;
    logic [AW-1:0] e_addr;
    logic [7:0]    e_data;

    function automatic logic [7:0] m_status();
        m_status = {(!m_busy || ack), (m_busy && ack), m_es, m_ps, m_vl, 3'b000};
    endfunction

    always @(posedge clk) begin
        bit sp, se, cl, nb;
        if (!rst_n || pd) begin
            m_mode = 0; m_arm = 0; m_busy = 0; m_erase_op = 0;
            m_es = 0; m_ps = 0; m_vl = 0; m_seen = 0; m_rd = 8'h00;
            e_prog = 0; e_erase = 0; e_susp = 0; e_res = 0;
        end else begin
            if (rd_en) begin
                if (m_mode == 0) m_rd = array_data;
                else if (m_mode == 2) m_rd = (rd_addr == 0) ? 8'h31 : (rd_addr == 1) ? 8'h7C : 8'h00;
                else if (!m_seen) m_rd = m_status();
            end
            m_seen = rd_en;
            e_prog = 0; e_erase = 0; e_susp = 0; e_res = 0;
            sp = 0; se = 0; cl = 0;
            nb = done ? 1'b0 : m_busy;
            if (wr_en) begin
                if (m_arm == 1) begin
                    m_arm = 0; m_mode = 1;
                    if (m_vl) sp = 1;
                    else begin e_prog = 1; e_addr = wr_addr; e_data = wr_data; nb = 1; end
                end else if (m_arm == 2) begin
                    m_arm = 0; m_mode = 1;
                    if (wr_data != 8'hD0) begin sp = 1; se = 1; end
                    else if (m_vl) se = 1;
                    else begin e_erase = 1; e_addr = wr_addr; nb = 1; end
                end else if (m_busy && !ack) begin
                    if (wr_data == 8'h70) m_mode = 1;
                    else if (wr_data == 8'hB0 && m_erase_op) e_susp = 1;
                end else if (m_busy) begin
                    if (wr_data == 8'h70) m_mode = 1;
                    else if (wr_data == 8'hFF) m_mode = 0;
                    else if (wr_data == 8'hD0) begin e_res = 1; m_mode = 1; end
                end else begin
                    case (wr_data)
                        8'hFF: m_mode = 0;
                        8'h70: m_mode = 1;
                        8'h50: cl = 1;
                        8'h90: m_mode = 2;
                        8'h40, 8'h10: begin m_arm = 1; m_mode = 1; end
                        8'h20: begin m_arm = 2; m_mode = 1; end
                        default: ;
                    endcase
                end
            end
            if (cl) begin m_es = 0; m_ps = 0; m_vl = 0; end
            if (sp) m_ps = 1;
            if (se) m_es = 1;
            if (done && (err || vlow)) begin
                if (m_erase_op) m_es = 1; else m_ps = 1;
            end
            if (done && vlow) m_vl = 1;
            if (e_prog) m_erase_op = 0;
            if (e_erase) m_erase_op = 1;
            m_busy = nb;
        end
    end

    // compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(m_mode == 1 ? "R6 rd_data" : (m_mode == 2 ? "R10 rd_data" : "R2 rd_data"),
                32'(rd_data), 32'(m_rd));
            chk("R3 prog_req", 32'(prog_req), 32'(e_prog));
            chk("R4 erase_req", 32'(erase_req), 32'(e_erase));
            chk("R9 susp_req", 32'(susp_req), 32'(e_susp));
            chk("R9 resume_req", 32'(resume_req), 32'(e_res));
            if (e_prog) begin
                chk("R3 seq_addr", 32'(seq_addr), 32'(e_addr));
                chk("R3 seq_data", 32'(seq_data), 32'(e_data));
            end
            if (e_erase) chk("R4 seq_addr", 32'(seq_addr), 32'(e_addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(posedge clk); #2;
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); #2;
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic finish_op(input logic e, input logic vl);
        @(posedge clk); #2;
        done = 1'b1; err = e; vlow = vl;
        @(posedge clk); #2;
        done = 1'b0; err = 1'b0; vlow = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        chk("R1 no request after reset", 32'({prog_req, erase_req, susp_req, resume_req}), 32'h0);
        rd(18'h00123, v); chk("R1 array mode after reset", 32'(v), 32'h79);
        wr(0, 8'h70); rd(0, v); chk("R1 idle status byte", 32'(v), 32'h80);

        // R10: identification
        wr(0, 8'h90);
        rd(0, v); chk("R10 maker code", 32'(v), 32'h31);
        rd(1, v); chk("R10 device code", 32'(v), 32'h7C);
        rd(2, v); chk("R10 other address", 32'(v), 32'h00);

        // R2 and R11
        wr(0, 8'hFF); rd(5, v); chk("R2 array read", 32'(v), 32'h5F);
        wr(0, 8'h33); rd(5, v); chk("R11 undefined kept array", 32'(v), 32'h5F);
        wr(0, 8'h70); wr(0, 8'h33); rd(9, v); chk("R11 undefined kept status", 32'(v), 32'h80);

        // R3, R8, R12, R7: program with error
        wr(0, 8'h40);
        wr(18'h01234, 8'hA5);
        chk("R3 prog_req pulse", 32'(prog_req), 32'h1);
        chk("R3 prog address", 32'(seq_addr), 32'h01234);
        chk("R3 prog data", 32'(seq_data), 32'hA5);
        rd(0, v); chk("R12 busy status", 32'(v), 32'h00);
        wr(0, 8'hFF); rd(0, v); chk("R8 FFh ignored while busy", 32'(v), 32'h00);
        finish_op(1'b1, 1'b0);
        rd(0, v); chk("R12 program error bit", 32'(v), 32'h90);
        wr(0, 8'h50); rd(0, v); chk("R7 clear status", 32'(v), 32'h80);

        // R5: bad erase sequence
        wr(18'h30000, 8'h20); wr(18'h30000, 8'h55);
        chk("R5 no erase request", 32'(erase_req), 32'h0);
        rd(0, v); chk("R5 both error bits", 32'(v), 32'hB0);
        wr(0, 8'h50);

        // R4, R8, R9: erase with suspend and resume
        wr(18'h30000, 8'h20); wr(18'h30010, 8'hD0);
        chk("R4 erase_req pulse", 32'(erase_req), 32'h1);
        chk("R4 erase address", 32'(seq_addr), 32'h30010);
        wr(0, 8'h40); rd(0, v); chk("R8 40h ignored while erasing", 32'(v), 32'h00);
        wr(0, 8'hB0);
        chk("R9 suspend request", 32'(susp_req), 32'h1);
        ack = 1'b1;
        rd(0, v); chk("R9 suspended status", 32'(v), 32'hC0);
        wr(0, 8'hFF); rd(7, v); chk("R9 array read while suspended", 32'(v), 32'h5D);
        wr(0, 8'hD0);
        chk("R9 resume request", 32'(resume_req), 32'h1);
        ack = 1'b0;
        rd(0, v); chk("R9 busy again after resume", 32'(v), 32'h00);
        finish_op(1'b0, 1'b0);
        rd(0, v); chk("R12 erase done clean", 32'(v), 32'h80);

        // R12, R13: low voltage
        wr(0, 8'h10); wr(18'h00044, 8'h3C);
        chk("R3 alternate program byte", 32'(prog_req), 32'h1);
        finish_op(1'b0, 1'b1);
        rd(0, v); chk("R12 voltage low bits", 32'(v), 32'h98);
        wr(0, 8'h20); wr(0, 8'hD0);
        chk("R13 erase blocked", 32'(erase_req), 32'h0);
        rd(0, v); chk("R13 erase error bit", 32'(v), 32'hB8);

        // R6: status frozen while strobe held
        @(posedge clk); #2 rd_en = 1'b1; rd_addr = '0;
        @(posedge clk); #2;
        chk("R6 status captured", 32'(rd_data), 32'hB8);
        wr_en = 1'b1; wr_data = 8'h50;
        @(posedge clk); #2 wr_en = 1'b0;
        @(posedge clk); #2;
        chk("R6 status held", 32'(rd_data), 32'hB8);
        rd_en = 1'b0;
        rd(0, v); chk("R6 status refreshed", 32'(v), 32'h80);

        // R1: deep power-down
        wr(0, 8'h90);
        @(posedge clk); #2 pd = 1'b1;
        @(posedge clk); #2;
        chk("R1 read zero in power-down", 32'(rd_data), 32'h00);
        @(posedge clk); #2 pd = 1'b0;
        rd(3, v); chk("R1 array mode after power-down", 32'(v), 32'h59);

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule